// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a single-cycle processor and works out the address to fetch next. Each cycle it takes the instruction word, a sign-extended immediate, a register operand, the ALU zero flag and four control bits that have already been decoded. From these it chooses between sequential flow, a conditional relative branch, an absolute region jump, a jump through a register, and a jump that also saves a return address. The program counter loads the chosen address on every rising clock edge.

For the linking jump, the block supplies the return address and a write-enable for register 31. The register file uses these to record where execution resumes. The selection logic is built around a small enumerated source type, `src_e`, with four values. `SRC_SEQ` means fall through, `SRC_BRANCH` means a taken branch, `SRC_REGION` means an absolute jump, and `SRC_REG` means a jump through a register. The source is picked each cycle by fixed priority. The only state is the program counter itself. It leaves reset and advances on each clock edge; there are no other transitions.

Top module: `npc_unit`

## Requirements
- R1: After a synchronous reset, `pc_q` reads 0 at the clock edge where `rst` is high.
- R2: When no control bit selects another source, `pc_q` advances by 4 at each rising edge, wrapping modulo 2^32.
- R3: When `is_branch` and `alu_zero` are both 1, the next `pc_q` is `pc_q + 4 + (imm_ext << 2)`. The immediate is a signed 32-bit value.
- R4: When `is_branch` is 1 but `alu_zero` is 0, or when `alu_zero` is 1 but `is_branch` is 0, the next `pc_q` is `pc_q + 4`.
- R5: When `is_jump` or `is_link` is 1, the next `pc_q` is formed from three parts, from high to low: `pc_q[31:28]`, then `instr[25:0]`, then two zero bits.
- R6: When `is_jreg` is 1, the next `pc_q` is `reg_val`.
- R7: Sources are chosen by fixed priority. `is_jreg` comes first. Next is `is_jump` or `is_link`. Next is a taken branch. Fall-through comes last.
- R8: `link_we` equals `is_link`, combinationally. `link_addr` always equals `pc_q + 4` of the current instruction. `link_reg` is the constant 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word |
| imm_ext | input | 32 | Sign-extended word offset |
| reg_val | input | 32 | Register operand used as the target of a register jump |
| alu_zero | input | 1 | ALU result-is-zero flag |
| is_branch | input | 1 | Conditional branch control bit |
| is_jump | input | 1 | Absolute jump control bit |
| is_jreg | input | 1 | Register jump control bit |
| is_link | input | 1 | Jump that also saves a return address |
| pc_q | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (`pc_q + 4`) |
| link_reg | output | 5 | Destination register index for the return address |
| link_we | output | 1 | Write-enable for the return address |

## Verification
A taken branch can arrive in the same cycle as an absolute jump, and a register jump can arrive in the same cycle as a linking jump. The bench drives each of these pairs together in one cycle. It judges the result by which of the expected targets appears on `pc_q` after the edge. The three targets are computed in the bench so that they all differ. When a linking jump is overridden by a register jump, the bench also checks that `link_we` and `link_addr` still report the return address of the linking instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int AW = 32;
    localparam int JFIELD = 26;
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_REGION = 2'd2,
        SRC_REG    = 2'd3
    } src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int W = AW,
    parameter int JW = JFIELD
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] imm_ext,
    output logic [W-1:0] seq_addr,
    output logic [W-1:0] br_addr,
    output logic [W-1:0] region_addr
);
    localparam int HI = W - JW - 2;

    always_comb begin
        seq_addr    = pc + W'(4);
        br_addr     = seq_addr + {imm_ext[W-3:0], 2'b00};
        region_addr = {pc[W-1 -: HI], instr[JW-1:0], 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic is_branch,
    input  logic alu_zero,
    input  logic is_jump,
    input  logic is_jreg,
    input  logic is_link,
    output src_e src
);
    always_comb begin
        if (is_jreg)                     src = SRC_REG;
        else if (is_jump || is_link)     src = SRC_REGION;
        else if (is_branch && alu_zero)  src = SRC_BRANCH;
        else                             src = SRC_SEQ;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int W = AW,
    parameter int RA_IDX = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] imm_ext,
    input  logic [W-1:0] reg_val,
    input  logic         alu_zero,
    input  logic         is_branch,
    input  logic         is_jump,
    input  logic         is_jreg,
    input  logic         is_link,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] link_addr,
    output logic [4:0]   link_reg,
    output logic         link_we
);
    logic [W-1:0] seq_addr, br_addr, region_addr, pc_d;
    src_e src;

    npc_targets #(.W(W), .JW(JFIELD)) targets_i (
        .pc(pc_q), .instr(instr), .imm_ext(imm_ext),
        .seq_addr(seq_addr), .br_addr(br_addr), .region_addr(region_addr)
    );

    npc_select select_i (
        .is_branch(is_branch), .alu_zero(alu_zero), .is_jump(is_jump),
        .is_jreg(is_jreg), .is_link(is_link), .src(src)
    );

    always_comb begin
        unique case (src)
            SRC_SEQ:    pc_d = seq_addr;
            SRC_BRANCH: pc_d = br_addr;
            SRC_REGION: pc_d = region_addr;
            SRC_REG:    pc_d = reg_val;
            default:    pc_d = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    always_comb begin
        link_addr = seq_addr;
        link_reg  = 5'(RA_IDX);
        link_we   = is_link;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> pc_q == '0);
    // R6
    jreg_target_chk: assert property (@(posedge clk) disable iff (rst)
        is_jreg |=> pc_q == $past(reg_val));
    // R2 R4
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_jreg && !is_jump && !is_link && !(is_branch && alu_zero))
        |=> pc_q == $past(pc_q) + W'(4));
    // R5
    region_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_jreg && (is_jump || is_link)) |=>
        (pc_q[W-1:W-4] == $past(pc_q[W-1:W-4]) && pc_q[1:0] == 2'b00));
    // R8
    link_we_chk: assert property (@(posedge clk) link_we == is_link);
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    logic clk = 0, rst = 1;
    logic [31:0] instr = 0, imm_ext = 0, reg_val = 0;
    logic alu_zero = 0, is_branch = 0, is_jump = 0, is_jreg = 0, is_link = 0;
    logic [31:0] pc_q, link_addr;
    logic [4:0] link_reg;
    logic link_we;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit dut_i (.clk(clk), .rst(rst), .instr(instr), .imm_ext(imm_ext),
        .reg_val(reg_val), .alu_zero(alu_zero), .is_branch(is_branch),
        .is_jump(is_jump), .is_jreg(is_jreg), .is_link(is_link),
        .pc_q(pc_q), .link_addr(link_addr), .link_reg(link_reg), .link_we(link_we));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic b, z, j, r, l);
        is_branch = b; alu_zero = z; is_jump = j; is_jreg = r; is_link = l;
    endtask

    // drive inputs at negedge, step one edge, sample at the next negedge
    task automatic step;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1; ctl(0,0,0,0,0); step(); rst = 0;
        chk("R1 reset", pc_q, 32'h0);
    endtask

    task automatic t_seq;
        logic [31:0] p;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            p = pc_q; step(); chk("R2 seq", pc_q, p + 4);
        end
    endtask

    task automatic t_branch;
        logic [31:0] p;
        do_reset(); step(); step();      // pc = 8
        p = pc_q; imm_ext = 32'd5; ctl(1,1,0,0,0); step();
        chk("R3 fwd branch", pc_q, p + 4 + 20);
        p = pc_q; imm_ext = 32'hFFFF_FFFC; step();
        chk("R3 back branch", pc_q, p + 4 - 16);
        p = pc_q; ctl(1,0,0,0,0); step();
        chk("R4 not taken", pc_q, p + 4);
        p = pc_q; ctl(0,1,0,0,0); step();
        chk("R4 zero only", pc_q, p + 4);
        ctl(0,0,0,0,0);
    endtask

    task automatic t_jump;
        logic [31:0] p;
        do_reset();
        instr = 32'h0BAD_CAFE; ctl(0,0,1,0,0); step();
        chk("R5 jump", pc_q, {4'h0, 26'h3AD_CAFE, 2'b00});
        instr = 32'h0000_0010; ctl(0,0,0,1,0); reg_val = 32'hA000_0100; step();
        chk("R6 jreg", pc_q, 32'hA000_0100);
        p = pc_q; ctl(0,0,0,0,1); instr = 32'h0000_0040;
        #1;
        chk("R8 link_we", {31'b0, link_we}, 32'd1);
        chk("R8 link_addr", link_addr, p + 4);
        chk("R8 link_reg", {27'b0, link_reg}, 32'd31);
        step();
        chk("R5 link target", pc_q, {4'hA, 26'h40, 2'b00});
        ctl(0,0,0,0,0); #1;
        chk("R8 no link_we", {31'b0, link_we}, 32'd0);
    endtask

    task automatic t_overlap;
        logic [31:0] p;
        do_reset();
        instr = 32'h0000_0100; imm_ext = 32'd3; ctl(1,1,1,0,0); step();
        chk("R7 jump over branch", pc_q, 32'h400);
        p = pc_q; reg_val = 32'h0000_2000; ctl(0,0,0,1,1); #1;
        chk("R8 link_we under jreg", {31'b0, link_we}, 32'd1);
        chk("R8 link_addr under jreg", link_addr, p + 4);
        step();
        chk("R7 jreg over link", pc_q, 32'h2000);
        ctl(1,1,1,1,0); reg_val = 32'h0000_3000; step();
        chk("R7 jreg over all", pc_q, 32'h3000);
        ctl(0,0,0,0,0);
    endtask

    task automatic t_wrap;
        do_reset();
        reg_val = 32'hFFFF_FFFC; ctl(0,0,0,1,0); step(); ctl(0,0,0,0,0); step();
        chk("R2 wrap", pc_q, 32'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_seq(); t_branch(); t_jump(); t_overlap(); t_wrap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule